// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Pending Count

This block gathers up to 32 level-sensitive interrupt lines and presents them to a processor through a small memory-mapped register window, 4 KiB wide and addressed by a 12-bit byte offset. Each line has a latched level bit and an enable bit. The block keeps a running tally of lines that are both latched and enabled, and it names the lowest-numbered such line. It drives a combined normal interrupt request and a fast interrupt request. The fast request has its own enable set, which has no write path and so stays clear.

Software unmasks or masks one line at a time by writing the line's number, not a bitmask, to the enable or disable offset. A flush write drops every latched level and zeroes the tally but keeps the enable set. Levels are latched on input transitions. A line that stays high after a flush stays cleared until it falls and rises again. Reads are combinational from the registered state. Writes and input transitions take effect at the next clock edge.

Top module: `irq_hub`

## Requirements
- R1: A read at offset 0x00 returns, zero-extended to 32 bits, the number of lines whose latched level and enable bits are both set. This equality holds in every cycle, including cycles where a line edge and a register write land together.
- R2: A read at offset 0x04 returns the index of the lowest-numbered line that is latched and enabled. It returns 0 when no line qualifies.
- R3: Writing a line number n below 32 to offset 0x10 sets enable bit n at the next edge. If line n is latched, it joins the tally.
- R4: Writing a line number n below 32 to offset 0x0C clears enable bit n at the next edge. If line n was latched, it leaves the tally.
- R5: A write to offset 0x08 clears every latched level and zeroes the tally at the next edge. It leaves all enable bits as they were.
- R6: A low-to-high input transition latches that line's level. A high-to-low transition clears it. An input held steady changes nothing, so a line held high after a flush stays unlatched.
- R7: The irq output is high exactly when at least one line is both latched and enabled.
- R8: The fiq output stays low, because the fast-interrupt enable set is never written.
- R9: Reads at offsets other than 0x00 and 0x04 return 0. Writes at offsets other than 0x08, 0x0C and 0x10 change nothing. Either kind of access sets the sticky bad_access output at the next edge, and it stays set until reset.
- R10: After reset the latched levels, enables and tally are all clear, and irq, fiq and bad_access are low.
- R11: An enable or disable write whose data is 32 or more changes no enable bit.
- R12: When a line edge and an enable, disable or flush write arrive in the same cycle, the flush is applied first, then the edge and the enable change together. The resulting tally is correct after that single edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt lines, one bit per line |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data (line number for enable/disable) |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| bad_access_o | output | 1 | Sticky flag for an access at an undefined offset |

## Verification
A tally that drifts away from the true latched-and-enabled population shows on the very next read of offset 0x00. It also breaks the agreement between irq and a nonzero tally, so the bench reads both registers after every clock and compares them with a model that keeps its own level and enable arrays. A wrong enable or level bit shows as a wrong lowest index or tally one cycle after the write or edge that caused it. A lost enable after a flush stays hidden until the line rises again, so the bench re-raises lines after each flush. Same-cycle collisions and long pseudo-random runs exercise the combined update path.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned AW = 12;
  localparam int unsigned DW = 32;

  localparam logic [AW-1:0] OFS_TALLY  = 12'h000;
  localparam logic [AW-1:0] OFS_FIRST  = 12'h004;
  localparam logic [AW-1:0] OFS_FLUSH  = 12'h008;
  localparam logic [AW-1:0] OFS_MASK   = 12'h00C;
  localparam logic [AW-1:0] OFS_UNMASK = 12'h010;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_FLUSH  = 2'd1,
    OP_MASK   = 2'd2,
    OP_UNMASK = 2'd3
  } reg_op_e;
endpackage

// File: rtl/irqc_state.sv
module irqc_state
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW = $clog2(NSRC),
  localparam int unsigned CW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  reg_op_e         op_i,
  input  logic            idx_ok_i,
  input  logic [IW-1:0]   idx_i,
  output logic [NSRC-1:0] level_o,
  output logic [NSRC-1:0] en_o,
  output logic [CW-1:0]   tally_o
);

  function automatic logic [CW-1:0] ones(input logic [NSRC-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int k = 0; k < NSRC; k++) n = n + CW'(v[k]);
    return n;
  endfunction

  function automatic logic [CW-1:0] next_tally(
    input logic [CW-1:0]   base,
    input logic [NSRC-1:0] was_on,
    input logic [NSRC-1:0] now_on
  );
    return base + ones(now_on & ~was_on) - ones(was_on & ~now_on);
  endfunction

  logic [NSRC-1:0] src_q, level_q, en_q;
  logic [NSRC-1:0] rise_w, fall_w, pick_w;
  logic [NSRC-1:0] level_base_w, level_n_w, en_n_w, act_old_w, act_new_w;
  logic [CW-1:0]   tally_q, tally_n_w;
  logic            flush_w;

  assign flush_w = (op_i == OP_FLUSH);

  for (genvar g = 0; g < NSRC; g++) begin : g_line
    assign rise_w[g]       = src_i[g] & ~src_q[g];
    assign fall_w[g]       = ~src_i[g] & src_q[g];
    assign pick_w[g]       = idx_ok_i && (idx_i == IW'(g));
    assign level_base_w[g] = flush_w ? 1'b0 : level_q[g];
    assign level_n_w[g]    = (level_base_w[g] | rise_w[g]) & ~fall_w[g];
    assign en_n_w[g]       = (op_i == OP_UNMASK) ? (en_q[g] | pick_w[g]) :
                             (op_i == OP_MASK)   ? (en_q[g] & ~pick_w[g]) : en_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g]   <= 1'b0;
        level_q[g] <= 1'b0;
        en_q[g]    <= 1'b0;
      end else begin
        src_q[g]   <= src_i[g];
        level_q[g] <= level_n_w[g];
        en_q[g]    <= en_n_w[g];
      end
    end
  end

  assign act_old_w = flush_w ? '0 : (level_q & en_q);
  assign act_new_w = level_n_w & en_n_w;
  assign tally_n_w = next_tally(flush_w ? '0 : tally_q, act_old_w, act_new_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tally_q <= '0;
    else        tally_q <= tally_n_w;
  end

  assign level_o = level_q;
  assign en_o    = en_q;
  assign tally_o = tally_q;

  a_r1_tally_is_population: assert property (@(posedge clk) disable iff (!rst_n)
    tally_q == CW'($countones(level_q & en_q)));

  a_r4_mask_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MASK && idx_ok_i) |=> !en_q[$past(idx_i)]);

  a_r3_unmask_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_UNMASK && idx_ok_i) |=> en_q[$past(idx_i)]);

  a_r5_flush_keeps_enables: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_FLUSH) |=> (en_q == $past(en_q)));

  a_r6_steady_input_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == src_q && op_i == OP_NONE) |=> (level_q == $past(level_q)));

endmodule

// File: rtl/irqc_first.sv
module irqc_first #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] act_i,
  output logic [IW-1:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (act_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irqc_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW = $clog2(NSRC),
  localparam int unsigned CW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_o,
  output logic            fiq_o,
  output logic            bad_access_o
);

  logic            is_rd_w, is_wr_w, rd_ok_w, wr_ok_w, bad_w, idx_ok_w;
  reg_op_e         op_w;
  logic [NSRC-1:0] level_w, en_w, act_w;
  logic [NSRC-1:0] fiq_en_q;
  logic [CW-1:0]   tally_w;
  logic [IW-1:0]   first_w;
  logic            bad_q;

  assign is_rd_w  = bus_sel & ~bus_wr;
  assign is_wr_w  = bus_sel & bus_wr;
  assign rd_ok_w  = (bus_addr == OFS_TALLY) || (bus_addr == OFS_FIRST);
  assign wr_ok_w  = (bus_addr == OFS_FLUSH) || (bus_addr == OFS_MASK) ||
                    (bus_addr == OFS_UNMASK);
  assign bad_w    = (is_rd_w & ~rd_ok_w) | (is_wr_w & ~wr_ok_w);
  assign idx_ok_w = (bus_wdata < DW'(NSRC));

  always_comb begin
    op_w = OP_NONE;
    if (is_wr_w) begin
      unique case (bus_addr)
        OFS_FLUSH:  op_w = OP_FLUSH;
        OFS_MASK:   op_w = OP_MASK;
        OFS_UNMASK: op_w = OP_UNMASK;
        default:    op_w = OP_NONE;
      endcase
    end
  end

  irqc_state #(.NSRC(NSRC)) i_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .op_i     (op_w),
    .idx_ok_i (idx_ok_w),
    .idx_i    (bus_wdata[IW-1:0]),
    .level_o  (level_w),
    .en_o     (en_w),
    .tally_o  (tally_w)
  );

  assign act_w = level_w & en_w;

  irqc_first #(.NSRC(NSRC)) i_first (
    .act_i (act_w),
    .idx_o (first_w)
  );

  always_comb begin
    bus_rdata = '0;
    if (is_rd_w) begin
      if (bus_addr == OFS_TALLY)      bus_rdata = DW'(tally_w);
      else if (bus_addr == OFS_FIRST) bus_rdata = DW'(first_w);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_en_q <= '0;
      bad_q    <= 1'b0;
    end else begin
      fiq_en_q <= fiq_en_q;
      bad_q    <= bad_q | bad_w;
    end
  end

  assign irq_o        = |act_w;
  assign fiq_o        = |(level_w & fiq_en_q);
  assign bad_access_o = bad_q;

  a_r7_irq_follows_tally: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (tally_w != '0));

  a_r8_fiq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_o);

  a_r9_bad_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |=> bad_q);

  a_r9_bad_sets: assert property (@(posedge clk) disable iff (!rst_n)
    bad_w |=> bad_q);

  a_r2_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (first_w == '0));

  a_r11_wide_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr_w && !idx_ok_w && bus_addr != OFS_FLUSH) |=> (en_w == $past(en_w)));

endmodule

// File: tb/test_irq_hub.sv
`timescale 1ns/100ps
module test_irq_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, fiq_o, bad_access_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic [31:0] m_lvl = '0, m_en = '0, m_prev = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o), .bad_access_o(bad_access_o)
  );

  function automatic int pop(input logic [31:0] v);
    int n = 0;
    while (v != 0) begin v = v & (v - 1); n++; end
    return n;
  endfunction

  function automatic int lowest(input logic [31:0] v);
    for (int k = 0; k < 32; k++) if (v[k]) return k;
    return 0;
  endfunction

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #0.3 v = bus_rdata;
    bus_sel = 1'b0;
    #0.1;
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(12'h000, v); ck("R1 tally", v, pop(m_lvl & m_en));
    rd(12'h004, v); ck("R2 first", v, lowest(m_lvl & m_en));
    ck("R7 irq", irq_o, (m_lvl & m_en) != 0);
    ck("R8 fiq", fiq_o, 0);
  endtask

  // drive at a falling edge, model the rising edge, check at the next falling edge
  task automatic step(input logic [31:0] s, input bit sel, input bit wr,
                      input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rise, fall;
    src_i = s; bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    rise = s & ~m_prev; fall = ~s & m_prev;
    if (sel && wr) begin
      if (a == 12'h008) m_lvl = '0;
      else if (a == 12'h00C && d < 32) m_en[d[4:0]] = 1'b0;
      else if (a == 12'h010 && d < 32) m_en[d[4:0]] = 1'b1;
    end
    m_lvl = (m_lvl | rise) & ~fall;
    m_prev = s;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check_all();
  endtask

  task automatic idle(input logic [31:0] s); step(s, 0, 0, 12'h000, 0); endtask
  task automatic wr(input logic [31:0] s, input logic [11:0] a, input logic [31:0] d);
    step(s, 1, 1, a, d);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    rd(12'h000, v); ck("R10 tally after reset", v, 0);
    rd(12'h004, v); ck("R10 first after reset", v, 0);
    ck("R10 irq after reset", irq_o, 0);
    ck("R10 fiq after reset", fiq_o, 0);
    ck("R10 bad after reset", bad_access_o, 0);

    // R3 R4 R6 per-line sweep
    for (int i = 0; i < 32; i++) begin
      idle(32'd1 << i);
      ck("R6 latched but masked", irq_o, 0);
      wr(32'd1 << i, 12'h010, i);
      rd(12'h004, v); ck("R3 unmask joins tally", v, i);
      idle(32'd1 << i);
      rd(12'h000, v); ck("R6 steady high no change", v, 1);
      wr(32'd1 << i, 12'h00C, i);
      rd(12'h000, v); ck("R4 mask leaves tally", v, 0);
      wr(32'd1 << i, 12'h010, i);
      idle(32'd0);
      rd(12'h000, v); ck("R6 fall clears level", v, 0);
      wr(32'd0, 12'h00C, i);
    end

    // multi-line patterns with all lines enabled
    for (int i = 0; i < 32; i++) wr(32'd0, 12'h010, i);
    idle(32'hA5A5_0F00);
    rd(12'h004, v); ck("R2 lowest of pattern", v, 8);
    for (int k = 1; k < 32; k++) idle(32'hFFFF_FFFF << k);
    idle(32'd0);
    idle(32'hFFFF_FFFF);
    rd(12'h000, v); ck("R1 full tally", v, 32);

    // R11 out-of-range indexes
    wr(32'hFFFF_FFFF, 12'h00C, 32);
    wr(32'hFFFF_FFFF, 12'h00C, 40);
    rd(12'h000, v); ck("R11 wide index ignored", v, 32);

    // R5 flush keeps enables, held line stays cleared
    wr(32'hFFFF_FFFF, 12'h008, 0);
    rd(12'h000, v); ck("R5 flush zeroes tally", v, 0);
    idle(32'hFFFF_FFFF);
    ck("R6 held line after flush", irq_o, 0);
    idle(32'd0);
    idle(32'h0000_0008);
    rd(12'h004, v); ck("R5 enable kept after flush", v, 3);

    // R12 same-cycle collisions
    for (int i = 0; i < 32; i++) wr(32'd0, 12'h00C, i);
    wr(32'h0000_0020, 12'h010, 5);
    rd(12'h000, v); ck("R12 rise with unmask", v, 1);
    wr(32'h0000_0000, 12'h00C, 5);
    rd(12'h000, v); ck("R12 fall with mask", v, 0);
    wr(32'h0000_0020, 12'h010, 5);
    wr(32'h0000_00A0, 12'h008, 0);
    rd(12'h000, v); ck("R12 rise with flush", v, 0);
    wr(32'h0000_00A0, 12'h010, 7);
    rd(12'h004, v); ck("R12 rise after flush latched", v, 7);

    // pseudo-random legal traffic, model checked every cycle (R1 R2 R7 R12)
    for (int t = 0; t < 4000; t++) begin
      logic [31:0] s;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      s = m_prev ^ (32'd1 << rng[4:0]) ^ (rng[9] ? (32'd1 << rng[14:10]) : 32'd0);
      case (rng[17:15])
        3'd0, 3'd1: wr(s, 12'h010, rng[22:18]);
        3'd2:       wr(s, 12'h00C, rng[22:18]);
        3'd3:       wr(s, 12'h008, 0);
        default:    idle(s);
      endcase
    end

    // R9 undefined offsets
    rd(12'h014, v); ck("R9 undefined read zero", v, 0);
    rd(12'h008, v); ck("R9 write-only read zero", v, 0);
    ck("R9 no flag before clocked access", bad_access_o, 0);
    step(m_prev, 1, 0, 12'h014, 0);
    ck("R9 flag set by bad read", bad_access_o, 1);
    step(m_prev, 1, 1, 12'h004, 0);
    step(m_prev, 1, 1, 12'hFFC, 3);
    idle(m_prev);
    ck("R9 flag sticky", bad_access_o, 1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule